// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block divides every CAN bit into time quanta and tracks where the current quantum lies within the bit. A bit has four segments in this order: a one-quantum synchronization segment, a propagation segment, a first phase segment and a second phase segment. The block advances one quantum for each cycle in which the quantum-rate enable is high. It reads the receive line once per quantum. At the end of the first phase segment it raises a sample strobe and reports the bus level seen in that quantum. It also marks the start of every bit with a one-cycle strobe.

The block follows the transmitter's clock by watching for falling edges, which are recessive-to-dominant transitions. A falling edge seen while the frame decoder reports an idle bus causes a hard restart of the bit. A falling edge seen inside a frame moves the sample point by at most the programmed jump width. A late edge lengthens the first phase segment. An early edge shortens the second phase segment. Only one such correction is made between two sample points. Prescaling, frame decoding, destuffing and error handling belong to the surrounding logic.

Top module: `can_bit_sync`

## Requirements
- R1: A bit without correction lasts 1 + prop_len + ph1_len + ph2_len quanta. bit_start pulses for the synchronization quantum, which is the first quantum after reset. A prop_len of zero removes the propagation segment.
- R2: sample_stb pulses for the last quantum of the first phase segment. In that same cycle sample_bit takes the rx_in level of that quantum (0 = dominant, 1 = recessive) and holds it until the next strobe.
- R3: Only cycles with tq_en high advance the bit. Each output reflects the quantum that ended at the previous clock edge. No strobe follows a cycle with tq_en low.
- R4: An edge is a quantum with rx_in dominant when the level taken at the previous sample point was recessive. An edge in the synchronization quantum changes no timing.
- R5: An edge in the propagation or first phase segment has a positive error e. e counts the quanta from the end of the synchronization quantum up to and including the edge quantum. The first phase segment of that bit grows by min(e, sjw_len).
- R6: An edge in the second phase segment has a negative error. Its magnitude is the number of quanta left in that segment, counting the edge quantum. The segment shrinks by min(magnitude, sjw_len). If the shortened segment is already used up, the next quantum is a synchronization quantum.
- R7: At most one synchronization, hard or resynchronization, is made between two sample points. Later edges before the next sample point are ignored.
- R8: A hard synchronization makes the edge quantum the synchronization quantum, with bit_start pulsing for it, whatever the phase error. The next quantum opens the propagation segment. A sample due in that same quantum is dropped, so sample_stb and bit_start never pulse together.
- R9: Hard synchronization is armed while bus_idle is high. It is disarmed by a hard synchronization or by a dominant sample. Inside a frame every edge is handled as a bounded resynchronization, so an error larger than sjw_len leaves a residue.
- R10: An edge in the quantum where the sample would fall moves the sample point later by the correction, and no strobe is issued in that quantum.
- R11: After reset, sample_stb and bit_start are 0 and sample_bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_en | input | 1 | One-cycle enable per time quantum |
| rx_in | input | 1 | Receive line, 0 = dominant |
| bus_idle | input | 1 | Frame decoder reports an idle bus; arms hard synchronization |
| prop_len | input | SEG_W | Propagation segment length in quanta (may be 0) |
| ph1_len | input | SEG_W | First phase segment length (at least 1) |
| ph2_len | input | SEG_W | Second phase segment length (at least 1) |
| sjw_len | input | SEG_W | Jump width (1 to the smaller phase segment) |
| sample_stb | output | 1 | Sample point strobe |
| sample_bit | output | 1 | Bus level at the latest sample point |
| bit_start | output | 1 | Synchronization quantum strobe |

## Verification
An edge can fall in the very quantum where the sample point would otherwise be taken, so synchronization and sampling compete for the same cycle. The bench places a falling edge in the last nominal quantum of the first phase segment, once with hard synchronization disarmed and once with it armed. Inside a frame the strobe must move two quanta later and carry the dominant level. With a hard restart the strobe must be dropped, a bit start reported in that quantum, and the sample taken a full nominal prefix later.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int unsigned CBT_MAG_W = 8;

  typedef logic [CBT_MAG_W-1:0] cbt_mag_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } cbt_seg_e;

  // smaller of an error magnitude and the jump width
  function automatic cbt_mag_t cbt_clip(input cbt_mag_t mag, input cbt_mag_t limit);
    return (mag < limit) ? mag : limit;
  endfunction

  // late edge: quanta from end of sync quantum up to and including the edge
  function automatic cbt_mag_t cbt_lead_err(input cbt_seg_e seg, input cbt_mag_t cnt,
                                            input cbt_mag_t prop);
    return (seg == SEG_PROP) ? cnt + cbt_mag_t'(1) : prop + cnt + cbt_mag_t'(1);
  endfunction

  // early edge: quanta left in phase 2, edge quantum included
  function automatic cbt_mag_t cbt_lag_err(input cbt_mag_t cnt, input cbt_mag_t ph2);
    return ph2 - cnt;
  endfunction

  // phase 2 exhausted after this quantum, given the cut applied
  function automatic logic cbt_ph2_done(input cbt_mag_t cnt, input cbt_mag_t cut,
                                        input cbt_mag_t ph2);
    return (cnt + cbt_mag_t'(1) + cut) >= ph2;
  endfunction

endpackage

// File: rtl/cbt_edge_watch.sv
module cbt_edge_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic rx,
  input  logic bus_idle,
  input  logic sample_now,
  output logic edge_hit,
  output logic hs_armed
);

  logic last_smp_q;
  logic synced_q;
  logic arm_q;

  // recessive at last sample point, dominant now, no sync yet this interval
  assign edge_hit = tq_en & last_smp_q & ~rx & ~synced_q;
  assign hs_armed = arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_smp_q <= 1'b1;
      synced_q   <= 1'b0;
      arm_q      <= 1'b0;
    end else begin
      if (sample_now) begin
        last_smp_q <= rx;
        synced_q   <= 1'b0;
      end else if (edge_hit) begin
        synced_q   <= 1'b1;
      end
      if ((sample_now && !rx) || (edge_hit && arm_q)) begin
        arm_q <= 1'b0;
      end else if (bus_idle) begin
        arm_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cbt_phase_calc.sv
module cbt_phase_calc
  import can_bt_pkg::*;
(
  input  cbt_seg_e seg,
  input  cbt_mag_t cnt,
  input  cbt_mag_t prop,
  input  cbt_mag_t ph2,
  input  cbt_mag_t sjw,
  output cbt_mag_t lead_step,
  output cbt_mag_t lag_step
);

  assign lead_step = cbt_clip(cbt_lead_err(seg, cnt, prop), sjw);
  assign lag_step  = cbt_clip(cbt_lag_err(cnt, ph2), sjw);

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import can_bt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tq_en,
  input  logic     hard_go,
  input  logic     lead_go,
  input  logic     lag_go,
  input  cbt_mag_t lead_step,
  input  cbt_mag_t lag_step,
  input  cbt_mag_t prop,
  input  cbt_mag_t ph1,
  input  cbt_mag_t ph2,
  output cbt_seg_e seg,
  output cbt_mag_t cnt,
  output logic     sample_now,
  output logic     bit_now
);

  cbt_seg_e seg_q;
  cbt_mag_t cnt_q;
  cbt_mag_t ext_q;
  cbt_mag_t cut_q;
  cbt_mag_t ext_now;
  cbt_mag_t cut_now;
  cbt_mag_t ph1_lim;
  cbt_seg_e first_seg;
  logic     prop_last;
  logic     ph1_last;
  logic     ph2_last;

  assign seg = seg_q;
  assign cnt = cnt_q;

  assign ext_now   = lead_go ? lead_step : ext_q;
  assign cut_now   = lag_go ? lag_step : cut_q;
  assign ph1_lim   = ph1 + ext_now;
  assign first_seg = (prop == '0) ? SEG_PH1 : SEG_PROP;

  assign prop_last = (seg_q == SEG_PROP) && (cnt_q + cbt_mag_t'(1) == prop);
  assign ph1_last  = (seg_q == SEG_PH1) && (cnt_q + cbt_mag_t'(1) == ph1_lim);
  assign ph2_last  = (seg_q == SEG_PH2) && cbt_ph2_done(cnt_q, cut_now, ph2);

  assign sample_now = tq_en & ~hard_go & ph1_last;
  assign bit_now    = tq_en & ((seg_q == SEG_SYNC) | hard_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
      ext_q <= '0;
      cut_q <= '0;
    end else if (tq_en) begin
      if (hard_go || seg_q == SEG_SYNC) begin
        seg_q <= first_seg;
        cnt_q <= '0;
        ext_q <= '0;
        cut_q <= '0;
      end else begin
        unique case (seg_q)
          SEG_PROP: begin
            ext_q <= ext_now;
            if (prop_last) begin
              seg_q <= SEG_PH1;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + cbt_mag_t'(1);
            end
          end
          SEG_PH1: begin
            ext_q <= ext_now;
            if (ph1_last) begin
              seg_q <= SEG_PH2;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + cbt_mag_t'(1);
            end
          end
          SEG_PH2: begin
            cut_q <= cut_now;
            if (ph2_last) begin
              seg_q <= SEG_SYNC;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + cbt_mag_t'(1);
            end
          end
          default: begin
            seg_q <= first_seg;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync
  import can_bt_pkg::*;
#(
  parameter int unsigned SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx_in,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SEG_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);

  cbt_mag_t prop_m;
  cbt_mag_t ph1_m;
  cbt_mag_t ph2_m;
  cbt_mag_t sjw_m;

  assign prop_m = cbt_mag_t'(prop_len);
  assign ph1_m  = cbt_mag_t'(ph1_len);
  assign ph2_m  = cbt_mag_t'(ph2_len);
  assign sjw_m  = cbt_mag_t'(sjw_len);

  // named internal events, visible to the bound checker
  logic     edge_hit;
  logic     hs_armed;
  logic     sync_taken;
  logic     hard_go;
  logic     lead_go;
  logic     lag_go;
  logic     sample_now;
  logic     bit_now;
  cbt_seg_e seg;
  cbt_mag_t cnt;
  cbt_mag_t lead_step;
  cbt_mag_t lag_step;

  assign sync_taken = edge_hit;
  assign hard_go    = edge_hit & hs_armed;
  assign lead_go    = edge_hit & ~hs_armed & ((seg == SEG_PROP) | (seg == SEG_PH1));
  assign lag_go     = edge_hit & ~hs_armed & (seg == SEG_PH2);

  cbt_edge_watch u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_en      (tq_en),
    .rx         (rx_in),
    .bus_idle   (bus_idle),
    .sample_now (sample_now),
    .edge_hit   (edge_hit),
    .hs_armed   (hs_armed)
  );

  cbt_phase_calc u_calc (
    .seg       (seg),
    .cnt       (cnt),
    .prop      (prop_m),
    .ph2       (ph2_m),
    .sjw       (sjw_m),
    .lead_step (lead_step),
    .lag_step  (lag_step)
  );

  cbt_seg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_en      (tq_en),
    .hard_go    (hard_go),
    .lead_go    (lead_go),
    .lag_go     (lag_go),
    .lead_step  (lead_step),
    .lag_step   (lag_step),
    .prop       (prop_m),
    .ph1        (ph1_m),
    .ph2        (ph2_m),
    .seg        (seg),
    .cnt        (cnt),
    .sample_now (sample_now),
    .bit_now    (bit_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_start  <= 1'b0;
    end else begin
      sample_stb <= sample_now;
      bit_start  <= bit_now;
      if (sample_now) sample_bit <= rx_in;
    end
  end

endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk
  import can_bt_pkg::*;
#(
  parameter int unsigned SEG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tq_en,
  input logic             rx_in,
  input logic [SEG_W-1:0] prop_len,
  input logic [SEG_W-1:0] ph1_len,
  input logic [SEG_W-1:0] ph2_len,
  input logic [SEG_W-1:0] sjw_len,
  input logic             sample_stb,
  input logic             sample_bit,
  input logic             bit_start,
  input logic             sync_taken,
  input logic             sample_now,
  input logic             bit_now
);

  logic     pend_q;
  cbt_mag_t gap_q;
  cbt_mag_t max_len;

  assign max_len = cbt_mag_t'(1) + cbt_mag_t'(prop_len) + cbt_mag_t'(ph1_len)
                 + cbt_mag_t'(sjw_len) + cbt_mag_t'(ph2_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      if (sample_now) pend_q <= 1'b0;
      else if (sync_taken) pend_q <= 1'b1;
      if (tq_en) gap_q <= bit_now ? cbt_mag_t'(1) : gap_q + cbt_mag_t'(1);
    end
  end

  // R3
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tq_en) |-> (!sample_stb && !bit_start));

  // R2
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(sample_bit));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start));

  // R7
  one_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_taken |-> !pend_q);

  // R4
  sync_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_taken |-> (tq_en && !rx_in));

  // R6
  bit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_en && !bit_now) |-> (gap_q < max_len));

endmodule

bind can_bit_sync can_bit_sync_chk #(.SEG_W(SEG_W)) u_can_bit_sync_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tq_en      (tq_en),
  .rx_in      (rx_in),
  .prop_len   (prop_len),
  .ph1_len    (ph1_len),
  .ph2_len    (ph2_len),
  .sjw_len    (sjw_len),
  .sample_stb (sample_stb),
  .sample_bit (sample_bit),
  .bit_start  (bit_start),
  .sync_taken (sync_taken),
  .sample_now (sample_now),
  .bit_now    (bit_now)
);

// File: tb/test_can_bit_sync.sv
module test_can_bit_sync;

  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tq_en = 1'b0;
  logic          rx_in = 1'b1;
  logic          bus_idle = 1'b0;
  logic [SW-1:0] prop_len = 4'd2;
  logic [SW-1:0] ph1_len = 4'd3;
  logic [SW-1:0] ph2_len = 4'd3;
  logic [SW-1:0] sjw_len = 4'd2;
  logic          sample_stb;
  logic          sample_bit;
  logic          bit_start;

  int nvec = 0;
  int nerr = 0;
  int samp_at [8];
  int samp_val[8];
  int start_at[8];
  int ns, nb, stall_hits;

  always #5 clk = ~clk;

  can_bit_sync #(.SEG_W(SW)) i_can_bit_sync (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_in(rx_in), .bus_idle(bus_idle),
    .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_start(bit_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int p, input int a, input int b, input int j);
    prop_len = p[SW-1:0]; ph1_len = a[SW-1:0]; ph2_len = b[SW-1:0]; sjw_len = j[SW-1:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tq_en = 1'b0; rx_in = 1'b1; bus_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // quantum i gets rx = pat[i]; outputs read one clock later
  task automatic run_seq(input int n, input logic [63:0] pat, input int stall,
                         input int idle_until);
    ns = 0; nb = 0; stall_hits = 0;
    for (int k = 0; k < 8; k++) begin
      samp_at[k] = -1; samp_val[k] = -1; start_at[k] = -1;
    end
    for (int i = 0; i < n; i++) begin
      rx_in = pat[i]; tq_en = 1'b1; bus_idle = (i < idle_until);
      @(negedge clk);
      if (sample_stb) begin
        if (ns < 8) begin samp_at[ns] = i; samp_val[ns] = int'(sample_bit); end
        ns++;
      end
      if (bit_start) begin
        if (nb < 8) start_at[nb] = i;
        nb++;
      end
      for (int s = 0; s < stall; s++) begin
        tq_en = 1'b0; rx_in = ~rx_in;
        @(negedge clk);
        if (sample_stb || bit_start) stall_hits++;
      end
    end
    tq_en = 1'b0; rx_in = 1'b1;
  endtask

  task automatic t_reset();
    cfg(2, 3, 3, 2); do_reset();
    chk("R11 sample_stb", int'(sample_stb), 0);
    chk("R11 bit_start", int'(bit_start), 0);
    chk("R11 sample_bit", int'(sample_bit), 1);
  endtask

  task automatic t_free();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(20, '1, 0, 0);
    chk("R1 first start", start_at[0], 0);
    chk("R1 second start", start_at[1], 9);
    chk("R1 third start", start_at[2], 18);
    chk("R2 sample pos", samp_at[0], 5);
    chk("R2 sample val", samp_val[0], 1);
  endtask

  task automatic t_stall();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(12, '1, 2, 0);
    chk("R3 sample pos with stalls", samp_at[0], 5);
    chk("R3 start with stalls", start_at[1], 9);
    chk("R3 quiet during stalls", stall_hits, 0);
  endtask

  task automatic t_noprop();
    cfg(0, 3, 3, 2); do_reset();
    run_seq(16, '1, 0, 0);
    chk("R1 no prop sample", samp_at[0], 3);
    chk("R1 no prop start", start_at[1], 7);
  endtask

  task automatic t_sync_edge();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(12, '0, 0, 0);
    chk("R4 sync edge sample", samp_at[0], 5);
    chk("R4 sync edge val", samp_val[0], 0);
    chk("R4 sync edge start", start_at[1], 9);
  endtask

  task automatic t_lead();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(14, 64'h3, 0, 0);
    chk("R5 lead e2 sample", samp_at[0], 7);
    chk("R5 lead e2 start", start_at[1], 11);
    cfg(2, 3, 3, 2); do_reset();
    run_seq(14, 64'h7, 0, 0);
    chk("R5 lead e3 clipped sample", samp_at[0], 7);
    chk("R5 lead e3 clipped start", start_at[1], 11);
    cfg(2, 3, 3, 1); do_reset();
    run_seq(14, 64'h3, 0, 0);
    chk("R5 lead sjw1 sample", samp_at[0], 6);
    chk("R5 lead sjw1 start", start_at[1], 10);
  endtask

  task automatic t_lag();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(16, 64'h7F, 0, 0);
    chk("R6 lag first sample val", samp_val[0], 1);
    chk("R6 lag edge7 start", start_at[1], 8);
    chk("R6 lag edge7 next sample", samp_at[1], 13);
    cfg(2, 3, 3, 2); do_reset();
    run_seq(12, 64'h3F, 0, 0);
    chk("R6 lag edge6 immediate start", start_at[1], 7);
    cfg(2, 3, 3, 1); do_reset();
    run_seq(12, 64'h3F, 0, 0);
    chk("R9 lag residue sjw1 start", start_at[1], 8);
  endtask

  task automatic t_once();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(20, 64'h1BF, 0, 0);
    chk("R7 first sync start", start_at[1], 7);
    chk("R7 second edge ignored sample", samp_at[1], 12);
    chk("R7 second edge ignored val", samp_val[1], 0);
    chk("R7 second edge ignored start", start_at[2], 16);
  endtask

  task automatic t_sample_edge();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(14, 64'h1F, 0, 0);
    chk("R10 moved sample", samp_at[0], 7);
    chk("R10 moved sample val", samp_val[0], 0);
    chk("R10 start", start_at[1], 11);
  endtask

  task automatic t_hard();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(16, 64'hF, 0, 64);
    chk("R8 hard start", start_at[1], 4);
    chk("R8 hard sample", samp_at[0], 9);
    chk("R8 hard next start", start_at[2], 13);
    cfg(2, 3, 3, 2); do_reset();
    run_seq(16, 64'h1F, 0, 64);
    chk("R8 hard in sample quantum start", start_at[1], 5);
    chk("R8 hard in sample quantum sample", samp_at[0], 10);
  endtask

  task automatic t_frame();
    cfg(2, 3, 3, 2); do_reset();
    run_seq(34, 64'h7 | (64'hFFF << 12), 0, 4);
    chk("R9 hard at frame start", start_at[1], 3);
    chk("R9 dominant start bit", samp_val[0], 0);
    chk("R9 in frame resync sample", samp_at[2], 28);
    chk("R9 in frame resync start", start_at[4], 32);
  endtask

  initial begin
    t_reset();
    t_free();
    t_stall();
    t_noprop();
    t_sync_edge();
    t_lead();
    t_lag();
    t_once();
    t_sample_edge();
    t_hard();
    t_frame();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #2000000;
    nvec++; nerr++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule